// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one operand descriptor into the byte address the operand lives at, in a 16-bit byte-addressed data space. Each descriptor carries an addressing-mode code, a base-register selector, an immediate-size code and a displacement field, and the block receives the current values of the five base registers alongside it. Memory modes add a displacement to the chosen base register, or use the displacement itself as the address. The displacement is either unsigned and as wide as the address, or short and signed, depending on the mode. All sums wrap modulo 2^16.

Operands that are not in memory pass through as well. An immediate is handed on, trimmed to its 8, 16 or 20-bit size. A register-direct operand is reported as needing no memory access. The result is registered and comes out exactly one clock after the request. It carries an is-memory flag and an error flag. The error flag marks a base register that the mode does not allow, a reserved mode, or a reserved immediate size.

Top module: `oper_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_vld, out_is_mem, out_err and out_value are all zero.
- R2: out_vld equals in_vld of the previous clock. In a cycle after in_vld was low, out_value, out_is_mem and out_err keep their previous values.
- R3: Mode code 0 (register direct) gives out_value 0, out_is_mem 0 and out_err 0, whatever the base selector.
- R4: Mode code 1 (immediate) gives out_is_mem 0 and out_value equal to the low 8, 16 or 20 bits of in_disp, zero-extended, for size codes 0, 1 and 2. Size code 3 is an error.
- R5: Mode code 2 (absolute) gives out_is_mem 1 and out_value equal to in_disp[15:0]. The base selector and in_disp[19:16] are ignored.
- R6: Mode code 3 (indirect) gives out_is_mem 1 and out_value equal to A0 (selector 0) or A1 (selector 1). Any other selector is an error.
- R7: Mode code 4 (address-register relative) gives A0 or A1 (selector 0 or 1) plus in_disp[15:0]. For example, A1=1110h with displacement 4 gives 1114h. Any other selector is an error.
- R8: Mode code 5 (static-base relative) gives SB (selector 2 only) plus in_disp[15:0]. For example, 150Eh + 2 gives 1510h. in_disp[19:16] is ignored.
- R9: Mode code 6 (frame/stack relative) gives FB (selector 3) or SP (selector 4) plus in_disp[7:0], sign-extended, with a range of -128 to +127. For example, SP=1514h with displacement FAh gives 150Eh. in_disp[19:8] is ignored.
- R10: An error result, caused by an illegal selector for modes 3 to 6, by mode code 7, or by immediate size 3, gives out_err 1, out_is_mem 0 and out_value 0. A correct result has out_err 0.
- R11: Every address sum wraps modulo 2^16. For example, FFFFh + 2 gives 0001h, and 0005h - 6 gives FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| in_mode | input | 3 | Addressing-mode code (0 to 7) |
| in_base | input | 3 | Base selector: 0 A0, 1 A1, 2 SB, 3 FB, 4 SP |
| in_imm_size | input | 2 | Immediate size: 0 8-bit, 1 16-bit, 2 20-bit |
| in_disp | input | 20 | Displacement, absolute address or immediate value |
| reg_a0 | input | 16 | Address register 0 |
| reg_a1 | input | 16 | Address register 1 |
| reg_sb | input | 16 | Static base register |
| reg_fb | input | 16 | Frame base register |
| reg_sp | input | 16 | Stack pointer |
| out_vld | output | 1 | Result strobe, one clock after in_vld |
| out_value | output | 20 | Address (zero-extended) or immediate value |
| out_is_mem | output | 1 | Operand needs a memory access |
| out_err | output | 1 | Illegal descriptor |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 16-bit long displacement, an 8-bit short displacement, and immediate widths of 8, 16 and 20 bits. These widths bring several cases within reach. Short displacements of 7Fh and 80h reach the sign boundary. Bases near FFFFh and 0000h wrap past the top and bottom of the space. Upper displacement bits can be filled with junk that the long and short modes must drop. Each of the three immediate widths can be shown to truncate a 20-bit pattern differently.

// File: rtl/oea_pkg.sv
package oea_pkg;

   typedef enum logic [2:0] {
      MD_REG = 3'd0,
      MD_IMM = 3'd1,
      MD_ABS = 3'd2,
      MD_IND = 3'd3,
      MD_ARR = 3'd4,
      MD_SBR = 3'd5,
      MD_FSR = 3'd6,
      MD_RSV = 3'd7
   } oea_mode_e;

   localparam int NUM_BASES = 5;
   localparam int SEL_W     = 3;

   localparam logic [SEL_W-1:0] BS_A0 = 3'd0;
   localparam logic [SEL_W-1:0] BS_A1 = 3'd1;
   localparam logic [SEL_W-1:0] BS_SB = 3'd2;
   localparam logic [SEL_W-1:0] BS_FB = 3'd3;
   localparam logic [SEL_W-1:0] BS_SP = 3'd4;

   localparam logic [NUM_BASES-1:0] ALLOW_ADDR  = 5'b00011;
   localparam logic [NUM_BASES-1:0] ALLOW_SB    = 5'b00100;
   localparam logic [NUM_BASES-1:0] ALLOW_FRAME = 5'b11000;

   localparam int NUM_IMM_SIZES = 3;

endpackage

// File: rtl/oea_base_sel.sv
module oea_base_sel
   import oea_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  oea_mode_e                       mode_i,
   input  logic [SEL_W-1:0]                sel_i,
   input  logic [NUM_BASES-1:0][ADDR_W-1:0] bases_i,
   output logic [ADDR_W-1:0]               base_o,
   output logic                            uses_base_o,
   output logic                            legal_o
);

   logic [NUM_BASES-1:0]             allow;
   logic [NUM_BASES-1:0]             hit;
   logic [NUM_BASES-1:0][ADDR_W-1:0] masked;

   always_comb begin
      case (mode_i)
         MD_IND, MD_ARR: allow = ALLOW_ADDR;
         MD_SBR:         allow = ALLOW_SB;
         MD_FSR:         allow = ALLOW_FRAME;
         default:        allow = '0;
      endcase
   end

   assign uses_base_o = (allow != '0);

   for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
      assign hit[g]    = (sel_i == SEL_W'(g)) && allow[g];
      assign masked[g] = hit[g] ? bases_i[g] : '0;
   end

   always_comb begin
      base_o = '0;
      for (int i = 0; i < NUM_BASES; i++) begin
         base_o = base_o | masked[i];
      end
   end

   assign legal_o = |hit;

endmodule

// File: rtl/oea_disp_fmt.sv
module oea_disp_fmt
   import oea_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LONG_W   = 16,
   parameter int SHORT_W  = 8,
   parameter int IMM_W    = 20,
   parameter int IMM_NW   = 8,
   parameter int IMM_MW   = 16
) (
   input  oea_mode_e         mode_i,
   input  logic [1:0]        size_i,
   input  logic [IMM_W-1:0]  disp_i,
   output logic [ADDR_W-1:0] offset_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic              size_ok_o
);

   logic [ADDR_W-1:0] long_off;
   logic [ADDR_W-1:0] short_off;
   logic [ADDR_W-1:0] abs_off;
   logic [NUM_IMM_SIZES-1:0][IMM_W-1:0] imm_opt;

   if (LONG_W >= ADDR_W) begin : g_long_trunc
      assign long_off = disp_i[ADDR_W-1:0];
   end else begin : g_long_zext
      assign long_off = ADDR_W'(disp_i[LONG_W-1:0]);
   end

   assign short_off = ADDR_W'($signed(disp_i[SHORT_W-1:0]));
   assign abs_off   = disp_i[ADDR_W-1:0];

   for (genvar g = 0; g < NUM_IMM_SIZES; g++) begin : g_imm
      localparam int W = (g == 0) ? IMM_NW : ((g == 1) ? IMM_MW : IMM_W);
      if (W >= IMM_W) begin : g_full
         assign imm_opt[g] = disp_i;
      end else begin : g_part
         assign imm_opt[g] = IMM_W'(disp_i[W-1:0]);
      end
   end

   always_comb begin
      case (mode_i)
         MD_ABS:         offset_o = abs_off;
         MD_ARR, MD_SBR: offset_o = long_off;
         MD_FSR:         offset_o = short_off;
         default:        offset_o = '0;
      endcase
   end

   assign size_ok_o = (size_i < 2'(NUM_IMM_SIZES));
   assign imm_o     = size_ok_o ? imm_opt[size_i] : '0;

endmodule

// File: rtl/oea_out_reg.sv
module oea_out_reg #(
   parameter int VAL_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [VAL_W-1:0] value_i,
   input  logic             mem_i,
   input  logic             err_i,
   output logic             vld_o,
   output logic [VAL_W-1:0] value_o,
   output logic             mem_o,
   output logic             err_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         value_o <= '0;
         mem_o   <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            value_o <= value_i;
            mem_o   <= mem_i;
            err_o   <= err_i;
         end
      end
   end

   assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vld_o == $past(vld_i)));

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(vld_i)) |-> ($stable(value_o) && $stable(mem_o) && $stable(err_o)));

endmodule

// File: rtl/oper_addr_gen.sv
module oper_addr_gen
   import oea_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int LONG_W  = 16,
   parameter int SHORT_W = 8,
   parameter int IMM_W   = 20,
   parameter int IMM_NW  = 8,
   parameter int IMM_MW  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [2:0]        in_mode,
   input  logic [2:0]        in_base,
   input  logic [1:0]        in_imm_size,
   input  logic [IMM_W-1:0]  in_disp,
   input  logic [ADDR_W-1:0] reg_a0,
   input  logic [ADDR_W-1:0] reg_a1,
   input  logic [ADDR_W-1:0] reg_sb,
   input  logic [ADDR_W-1:0] reg_fb,
   input  logic [ADDR_W-1:0] reg_sp,
   output logic              out_vld,
   output logic [IMM_W-1:0]  out_value,
   output logic              out_is_mem,
   output logic              out_err
);

   localparam int VAL_W = IMM_W;

   if (SHORT_W < 2 || SHORT_W >= ADDR_W) begin : g_chk_short
      $error("short displacement width must lie between 2 and ADDR_W-1");
   end
   if (LONG_W < 1 || LONG_W > IMM_W) begin : g_chk_long
      $error("long displacement width must lie between 1 and IMM_W");
   end
   if (IMM_W < ADDR_W) begin : g_chk_imm
      $error("operand value width must cover the address");
   end
   if (IMM_NW < 1 || IMM_NW > IMM_MW || IMM_MW > IMM_W) begin : g_chk_sizes
      $error("immediate widths must be ordered and fit IMM_W");
   end

   oea_mode_e mode;
   assign mode = oea_mode_e'(in_mode);

   logic [NUM_BASES-1:0][ADDR_W-1:0] bases;
   assign bases[BS_A0] = reg_a0;
   assign bases[BS_A1] = reg_a1;
   assign bases[BS_SB] = reg_sb;
   assign bases[BS_FB] = reg_fb;
   assign bases[BS_SP] = reg_sp;

   logic [ADDR_W-1:0] base_val;
   logic              uses_base;
   logic              base_legal;
   logic [ADDR_W-1:0] offset;
   logic [IMM_W-1:0]  imm_val;
   logic              size_ok;
   logic [ADDR_W-1:0] addr;
   logic              nxt_err;
   logic              nxt_mem;
   logic [VAL_W-1:0]  nxt_value;

   oea_base_sel #(
      .ADDR_W (ADDR_W)
   ) i_base_sel (
      .mode_i      (mode),
      .sel_i       (in_base),
      .bases_i     (bases),
      .base_o      (base_val),
      .uses_base_o (uses_base),
      .legal_o     (base_legal)
   );

   oea_disp_fmt #(
      .ADDR_W  (ADDR_W),
      .LONG_W  (LONG_W),
      .SHORT_W (SHORT_W),
      .IMM_W   (IMM_W),
      .IMM_NW  (IMM_NW),
      .IMM_MW  (IMM_MW)
   ) i_disp_fmt (
      .mode_i    (mode),
      .size_i    (in_imm_size),
      .disp_i    (in_disp),
      .offset_o  (offset),
      .imm_o     (imm_val),
      .size_ok_o (size_ok)
   );

   // modulo 2^ADDR_W sum; absolute mode sees a zero base
   assign addr = base_val + offset;

   always_comb begin
      nxt_err = 1'b0;
      case (mode)
         MD_RSV:  nxt_err = 1'b1;
         MD_IMM:  nxt_err = !size_ok;
         default: nxt_err = uses_base && !base_legal;
      endcase
   end

   always_comb begin
      nxt_mem   = 1'b0;
      nxt_value = '0;
      if (!nxt_err) begin
         case (mode)
            MD_IMM: nxt_value = imm_val;
            MD_ABS, MD_IND, MD_ARR, MD_SBR, MD_FSR: begin
               nxt_mem   = 1'b1;
               nxt_value = VAL_W'(addr);
            end
            default: nxt_value = '0;
         endcase
      end
   end

   oea_out_reg #(
      .VAL_W (VAL_W)
   ) i_out_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (in_vld),
      .value_i (nxt_value),
      .mem_i   (nxt_mem),
      .err_i   (nxt_err),
      .vld_o   (out_vld),
      .value_o (out_value),
      .mem_o   (out_is_mem),
      .err_o   (out_err)
   );

   assert_reg_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_vld) && $past(in_mode) == 3'd0)
         |-> (!out_is_mem && !out_err && out_value == '0));

   assert_indirect_a1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_vld) && $past(in_mode) == 3'd3 && $past(in_base) == BS_A1)
         |-> (out_is_mem && out_value == VAL_W'($past(reg_a1))));

   assert_frame_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_vld) && $past(in_mode) == 3'd6 && $past(in_base) == BS_SP)
         |-> (out_value == VAL_W'(ADDR_W'($past(reg_sp)
                 + ADDR_W'($signed($past(in_disp[SHORT_W-1:0])))))));

   assert_err_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_err) |-> (!out_is_mem && out_value == '0));

   assert_reserved_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_vld) && $past(in_mode) == 3'd7) |-> out_err);

endmodule

// File: tb/test_oper_addr_gen.sv
module test_oper_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [2:0]  in_mode = '0;
   logic [2:0]  in_base = '0;
   logic [1:0]  in_imm_size = '0;
   logic [19:0] in_disp = '0;
   logic [15:0] reg_a0 = '0, reg_a1 = '0, reg_sb = '0, reg_fb = '0, reg_sp = '0;
   logic        out_vld;
   logic [19:0] out_value;
   logic        out_is_mem;
   logic        out_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int last_val  = 0;
   bit last_mem  = 1'b0;
   bit last_err  = 1'b0;

   always #10 clk = ~clk;

   oper_addr_gen i_oper_addr_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_vld      (in_vld),
      .in_mode     (in_mode),
      .in_base     (in_base),
      .in_imm_size (in_imm_size),
      .in_disp     (in_disp),
      .reg_a0      (reg_a0),
      .reg_a1      (reg_a1),
      .reg_sb      (reg_sb),
      .reg_fb      (reg_fb),
      .reg_sp      (reg_sp),
      .out_vld     (out_vld),
      .out_value   (out_value),
      .out_is_mem  (out_is_mem),
      .out_err     (out_err)
   );

   function automatic int base_of(input int sel);
      case (sel)
         0: return int'(reg_a0);
         1: return int'(reg_a1);
         2: return int'(reg_sb);
         3: return int'(reg_fb);
         4: return int'(reg_sp);
         default: return 0;
      endcase
   endfunction

   task automatic model(input int m, input int sel, input int sz, input int d,
                        output int val, output bit mem, output bit err);
      int off;
      val = 0; mem = 1'b0; err = 1'b0;
      case (m)
         0: ;
         1: begin
            if (sz == 0)      val = d % 256;
            else if (sz == 1) val = d % 65536;
            else if (sz == 2) val = d % 1048576;
            else              err = 1'b1;
         end
         2: begin val = d % 65536; mem = 1'b1; end
         3: begin
            if (sel <= 1) begin val = base_of(sel); mem = 1'b1; end
            else err = 1'b1;
         end
         4, 5: begin
            if ((m == 4 && sel <= 1) || (m == 5 && sel == 2)) begin
               val = (base_of(sel) + d % 65536) % 65536; mem = 1'b1;
            end else err = 1'b1;
         end
         6: begin
            if (sel == 3 || sel == 4) begin
               off = d % 256;
               if (off > 127) off = off - 256;
               val = (base_of(sel) + off + 65536) % 65536; mem = 1'b1;
            end else err = 1'b1;
         end
         default: err = 1'b1;
      endcase
   endtask

   task automatic compare(input bit exp_vld, input string tag);
      checks++;
      if (out_vld !== exp_vld || int'(out_value) != last_val ||
          out_is_mem !== last_mem || out_err !== last_err) begin
         fails++;
         $display("FAIL %s: got vld=%0b val=%05h mem=%0b err=%0b, expected vld=%0b val=%05h mem=%0b err=%0b",
                  tag, out_vld, out_value, out_is_mem, out_err,
                  exp_vld, last_val, last_mem, last_err);
      end
   endtask

   // called at a falling edge; result appears after the next rising edge
   task automatic apply(input bit v, input int m, input int sel, input int sz,
                        input int d, input string tag);
      int  val;
      bit  mem, err;
      in_vld      = v;
      in_mode     = 3'(m);
      in_base     = 3'(sel);
      in_imm_size = 2'(sz);
      in_disp     = 20'(d);
      if (v) begin
         model(m, sel, sz, d, val, mem, err);
         last_val = val; last_mem = mem; last_err = err;
      end
      @(negedge clk);
      compare(v, tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare(1'b0, "R1 after reset");

      reg_a0 = 16'h81A6; reg_a1 = 16'h1110; reg_sb = 16'h150E;
      reg_fb = 16'h0217; reg_sp = 16'h1514;

      apply(1, 0, 0, 0, 20'h12345, "R3 reg direct sel0");
      apply(1, 0, 7, 0, 20'hFFFFF, "R3 reg direct sel7");

      apply(1, 1, 0, 0, 20'hABCDE, "R4 imm 8");
      apply(1, 1, 0, 1, 20'hABCDE, "R4 imm 16");
      apply(1, 1, 6, 2, 20'hABCDE, "R4 imm 20");
      apply(1, 1, 0, 3, 20'hABCDE, "R4 imm size3 error");

      apply(1, 2, 0, 0, 20'h0213A, "R5 absolute");
      apply(1, 2, 6, 0, 20'hF81A8, "R5 absolute upper ignored");

      apply(0, 3, 0, 0, 20'h00000, "R2 idle holds");
      apply(0, 6, 7, 3, 20'hFFFFF, "R2 idle holds again");

      apply(1, 3, 0, 0, 20'h00000, "R6 indirect A0");
      apply(1, 3, 1, 0, 20'h00055, "R6 indirect A1");
      apply(1, 3, 2, 0, 20'h00000, "R6 indirect SB illegal");

      apply(1, 4, 1, 0, 20'h00004, "R7 relative A1+4");
      apply(1, 4, 0, 0, 20'h00010, "R7 relative A0+10h");
      apply(1, 4, 3, 0, 20'h00004, "R7 relative FB illegal");

      apply(1, 5, 2, 0, 20'h00002, "R8 static base +2");
      apply(1, 5, 2, 0, 20'h30002, "R8 static upper ignored");
      apply(1, 5, 0, 0, 20'h00002, "R8 static A0 illegal");

      apply(1, 6, 4, 0, 20'h000FA, "R9 SP-6");
      apply(1, 6, 3, 0, 20'h0007F, "R9 FB+127");
      apply(1, 6, 3, 0, 20'h00080, "R9 FB-128");
      apply(1, 6, 4, 0, 20'hFF1FA, "R9 upper ignored");
      apply(1, 6, 2, 0, 20'h000FA, "R9 SB illegal");

      apply(1, 7, 0, 0, 20'h00001, "R10 reserved mode");
      apply(1, 3, 5, 0, 20'h00001, "R10 selector 5");
      apply(1, 2, 0, 0, 20'h00777, "R10 clean after error");

      reg_a0 = 16'h81A6; reg_sb = 16'hFFFF; reg_sp = 16'h0005; reg_fb = 16'hFF90;
      apply(1, 4, 0, 0, 20'h0FFFF, "R11 A0+FFFFh wraps");
      apply(1, 5, 2, 0, 20'h00002, "R11 FFFFh+2 wraps");
      apply(1, 6, 4, 0, 20'h000FA, "R11 5-6 wraps");
      apply(1, 6, 3, 0, 20'h0007F, "R11 FB+127 wraps");

      apply(0, 0, 0, 0, 20'h00000, "R2 final idle");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule